// File: doc/BRIEF.md
# Configurable Logic Cell With Registers

The cell packs two four-input lookup functions (F and G), a three-input second-level lookup (H), two output multiplexers and a pair of storage elements. Each lookup's contents are a truth table on static configuration inputs. H can combine F and G, or take the place of either one through external control lines. The cell's combinational results leave on `x_o` and `y_o`. Its registered results leave on `xq_o` and `yq_o`.

Four control lines feed the cell. In order, line 0 is the fixed H middle input, line 1 is the direct data input (and alternate H upper input), line 2 is the set/reset request (and alternate H lower input), and line 3 is the clock enable. Each storage element is configured on its own for:
- its data source;
- clock polarity;
- flip-flop or latch behaviour;
- whether the enable and set/reset lines are used;
- the value it takes on set/reset.

An output bypass can replace a register output with any control line. The active-low `rst_ni` acts as the global set/reset. All per-register configuration vectors use bit 0 (or field [1:0]) for the X register and bit 1 (or field [3:2]) for the Y register.

Top module: `logic_cell`

## Requirements
- R1: F is `cfg_f_tt_i[f_in_i]` and G is `cfg_g_tt_i[g_in_i]`, with the input vector used directly as the truth-table bit index. With `cfg_x_h_i`=0, `x_o` shows F. With `cfg_y_h_i`=0, `y_o` shows G.
- R2: H is `cfg_h_tt_i[{b, ctrl_i[0], a}]`. Here a is F when `cfg_h_src_i[0]`=1 and `ctrl_i[2]` otherwise. b is G when `cfg_h_src_i[1]`=1 and `ctrl_i[1]` otherwise. `x_o` shows H when `cfg_x_h_i`=1, and `y_o` shows H when `cfg_y_h_i`=1.
- R3: Each register's data source field (`cfg_dsel_i`) selects 0 for F, 1 for G, 2 for H and 3 for `ctrl_i[1]`. In flip-flop mode the register captures that value on the rising edge of its effective clock while enabled.
- R4: With its `cfg_clk_inv_i` bit set, a register's effective clock is the inverted clock, so a flip-flop captures on the falling edge of `clk_i`. The other register is unaffected.
- R5: A register is enabled when `ctrl_i[3]` is high, or always when its `cfg_en_use_i` bit is 0. A disabled register holds its value.
- R6: With its `cfg_sr_use_i` bit set, a high `ctrl_i[2]` forces the register to its `cfg_srval_i` bit (1 = set, 0 = reset) at once, overriding clock and enable. With the bit clear, `ctrl_i[2]` has no effect on that register.
- R7: While `rst_ni` is low, both registers are forced asynchronously to their `cfg_srval_i` values. This includes power-up.
- R8: With its `cfg_latch_i` bit set, a register is transparent while its effective clock is high and it is enabled, and it holds otherwise.
- R9: With its `cfg_byp_en_i` bit set, `xq_o` (or `yq_o`) shows `ctrl_i[k]`, where k is `cfg_byp_src_i[1:0]` (or `[3:2]`), instead of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock |
| rst_ni | input | 1 | Global set/reset, active low, asynchronous |
| f_in_i | input | LUT_IN | F lookup inputs |
| g_in_i | input | LUT_IN | G lookup inputs |
| ctrl_i | input | 4 | Control lines: H middle, direct data, set/reset, enable |
| cfg_f_tt_i | input | 2**LUT_IN | F truth table |
| cfg_g_tt_i | input | 2**LUT_IN | G truth table |
| cfg_h_tt_i | input | 8 | H truth table |
| cfg_h_src_i | input | 2 | H input sources: bit 0 lower (F or ctrl 2), bit 1 upper (G or ctrl 1) |
| cfg_x_h_i | input | 1 | X output shows H instead of F |
| cfg_y_h_i | input | 1 | Y output shows H instead of G |
| cfg_dsel_i | input | 4 | Register data source, 2 bits per register |
| cfg_en_use_i | input | 2 | Register uses the enable line |
| cfg_sr_use_i | input | 2 | Register uses the set/reset line |
| cfg_srval_i | input | 2 | Set/reset value per register |
| cfg_clk_inv_i | input | 2 | Clock inversion per register |
| cfg_latch_i | input | 2 | Latch mode per register |
| cfg_byp_en_i | input | 2 | Output bypass enable per register |
| cfg_byp_src_i | input | 4 | Bypass control line index, 2 bits per register |
| x_o | output | 1 | Combinational X output |
| y_o | output | 1 | Combinational Y output |
| xq_o | output | 1 | Registered or bypassed X output |
| yq_o | output | 1 | Registered or bypassed Y output |

## Verification
The bench builds the cell with the default four-input lookups, which keeps each table at sixteen entries. This makes an exhaustive sweep practical: every pair of F and G input vectors, every value of the three control lines feeding H, and all four H source choices, repeated for several random truth-table sets, with both output multiplexer settings. The storage elements are taken through each mode in turn:
- edge capture from every data source;
- falling-edge capture and enable hold;
- asynchronous set/reset with per-register disabling, and global set/reset;
- latch transparency and the output bypass.

// File: rtl/cell_pkg.sv
`timescale 1ns/1ps
package cell_pkg;
  localparam int NCTRL    = 4;
  localparam int NREG     = 2;
  localparam int CTRL_H1  = 0;
  localparam int CTRL_DIN = 1;
  localparam int CTRL_SR  = 2;
  localparam int CTRL_EC  = 3;
  localparam int H_IN     = 3;

  typedef enum logic [1:0] {
    DSEL_F   = 2'd0,
    DSEL_G   = 2'd1,
    DSEL_H   = 2'd2,
    DSEL_DIN = 2'd3
  } dsel_e;
endpackage

// File: rtl/cell_lut.sv
`timescale 1ns/1ps
module cell_lut #(
  parameter int K = 4,
  localparam int ENTRIES = 1 << K
) (
  input  logic [K-1:0]       sel_i,
  input  logic [ENTRIES-1:0] tt_i,
  output logic               o
);
  assign o = tt_i[sel_i];
endmodule

// File: rtl/cell_store.sv
`timescale 1ns/1ps
module cell_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic en_i,
  input  logic sr_i,
  input  logic srval_i,
  input  logic clk_inv_i,
  input  logic latch_i,
  output logic q_o
);
  logic clk_eff;
  logic arst;
  logic ff_q;
  logic lat_q;

  assign clk_eff = clk_i ^ clk_inv_i;
  // local and global set/reset share one asynchronous term
  assign arst    = ~rst_ni | sr_i;

  always_ff @(posedge clk_eff or posedge arst) begin
    if (arst)      ff_q <= srval_i;
    else if (en_i) ff_q <= d_i;
  end

  always_latch begin
    if (arst)                 lat_q = srval_i;
    else if (clk_eff && en_i) lat_q = d_i;
  end

  assign q_o = latch_i ? lat_q : ff_q;
endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
  import cell_pkg::*;
#(
  parameter int LUT_IN = 4,
  localparam int LUT_BITS = 1 << LUT_IN,
  localparam int H_BITS   = 1 << H_IN
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LUT_IN-1:0]   f_in_i,
  input  logic [LUT_IN-1:0]   g_in_i,
  input  logic [NCTRL-1:0]    ctrl_i,
  input  logic [LUT_BITS-1:0] cfg_f_tt_i,
  input  logic [LUT_BITS-1:0] cfg_g_tt_i,
  input  logic [H_BITS-1:0]   cfg_h_tt_i,
  input  logic [1:0]          cfg_h_src_i,
  input  logic                cfg_x_h_i,
  input  logic                cfg_y_h_i,
  input  logic [2*NREG-1:0]   cfg_dsel_i,
  input  logic [NREG-1:0]     cfg_en_use_i,
  input  logic [NREG-1:0]     cfg_sr_use_i,
  input  logic [NREG-1:0]     cfg_srval_i,
  input  logic [NREG-1:0]     cfg_clk_inv_i,
  input  logic [NREG-1:0]     cfg_latch_i,
  input  logic [NREG-1:0]     cfg_byp_en_i,
  input  logic [2*NREG-1:0]   cfg_byp_src_i,
  output logic                x_o,
  output logic                y_o,
  output logic                xq_o,
  output logic                yq_o
);
  logic f_out, g_out, h_out;
  logic h_lo, h_hi;
  logic reg_d [NREG];
  logic reg_q [NREG];
  logic out_q [NREG];

  cell_lut #(.K(LUT_IN)) u_f (.sel_i(f_in_i), .tt_i(cfg_f_tt_i), .o(f_out));
  cell_lut #(.K(LUT_IN)) u_g (.sel_i(g_in_i), .tt_i(cfg_g_tt_i), .o(g_out));

  assign h_lo = cfg_h_src_i[0] ? f_out : ctrl_i[CTRL_SR];
  assign h_hi = cfg_h_src_i[1] ? g_out : ctrl_i[CTRL_DIN];

  cell_lut #(.K(H_IN)) u_h (
    .sel_i({h_hi, ctrl_i[CTRL_H1], h_lo}),
    .tt_i (cfg_h_tt_i),
    .o    (h_out)
  );

  assign x_o = cfg_x_h_i ? h_out : f_out;
  assign y_o = cfg_y_h_i ? h_out : g_out;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_comb begin
      unique case (dsel_e'(cfg_dsel_i[2*r +: 2]))
        DSEL_F:  reg_d[r] = f_out;
        DSEL_G:  reg_d[r] = g_out;
        DSEL_H:  reg_d[r] = h_out;
        default: reg_d[r] = ctrl_i[CTRL_DIN];
      endcase
    end

    cell_store u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (reg_d[r]),
      .en_i     (~cfg_en_use_i[r] | ctrl_i[CTRL_EC]),
      .sr_i     (cfg_sr_use_i[r] & ctrl_i[CTRL_SR]),
      .srval_i  (cfg_srval_i[r]),
      .clk_inv_i(cfg_clk_inv_i[r]),
      .latch_i  (cfg_latch_i[r]),
      .q_o      (reg_q[r])
    );

    assign out_q[r] = cfg_byp_en_i[r] ? ctrl_i[cfg_byp_src_i[2*r +: 2]] : reg_q[r];
  end

  assign xq_o = out_q[0];
  assign yq_o = out_q[1];
endmodule

// File: rtl/cell_chk.sv
`timescale 1ns/1ps
module cell_chk
  import cell_pkg::*;
#(
  parameter int LUT_IN = 4,
  localparam int LUT_BITS = 1 << LUT_IN,
  localparam int H_BITS   = 1 << H_IN
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [LUT_IN-1:0]   f_in_i,
  input logic [LUT_IN-1:0]   g_in_i,
  input logic [NCTRL-1:0]    ctrl_i,
  input logic [LUT_BITS-1:0] cfg_f_tt_i,
  input logic [LUT_BITS-1:0] cfg_g_tt_i,
  input logic [H_BITS-1:0]   cfg_h_tt_i,
  input logic [1:0]          cfg_h_src_i,
  input logic                cfg_x_h_i,
  input logic                cfg_y_h_i,
  input logic [2*NREG-1:0]   cfg_dsel_i,
  input logic [NREG-1:0]     cfg_en_use_i,
  input logic [NREG-1:0]     cfg_sr_use_i,
  input logic [NREG-1:0]     cfg_srval_i,
  input logic [NREG-1:0]     cfg_clk_inv_i,
  input logic [NREG-1:0]     cfg_latch_i,
  input logic [NREG-1:0]     cfg_byp_en_i,
  input logic [2*NREG-1:0]   cfg_byp_src_i,
  input logic                x_o,
  input logic                y_o,
  input logic                xq_o,
  input logic                yq_o
);
  logic [13:0] cfg_word;
  logic sr_x, sr_y;

  assign cfg_word = {cfg_dsel_i, cfg_en_use_i, cfg_sr_use_i,
                     cfg_clk_inv_i, cfg_latch_i, cfg_byp_en_i};
  assign sr_x = cfg_sr_use_i[0] & ctrl_i[CTRL_SR];
  assign sr_y = cfg_sr_use_i[1] & ctrl_i[CTRL_SR];

  // R1
  x_from_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_x_h_i |-> x_o == cfg_f_tt_i[f_in_i]);

  // R3
  x_din_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dsel_i[1:0] == 2'd3 && !cfg_latch_i[0] && !cfg_clk_inv_i[0] &&
     !cfg_byp_en_i[0] && (!cfg_en_use_i[0] || ctrl_i[CTRL_EC]) && !sr_x)
    |=> (!$stable(cfg_word) || sr_x || xq_o == $past(ctrl_i[CTRL_DIN])));

  // R5
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_latch_i[1] && !cfg_clk_inv_i[1] && !cfg_byp_en_i[1] &&
     cfg_en_use_i[1] && !ctrl_i[CTRL_EC] && !sr_y)
    |=> (!$stable(cfg_word) || sr_y || $stable(yq_o)));

  // R6
  x_sr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_x && !cfg_byp_en_i[0]) |-> xq_o == cfg_srval_i[0]);

  // R9
  y_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_byp_en_i[1] |-> yq_o == ctrl_i[cfg_byp_src_i[3:2]]);
endmodule

bind logic_cell cell_chk #(.LUT_IN(LUT_IN)) u_chk (.*);

// File: tb/logic_cell_bench.sv
`timescale 1ns/1ps
module logic_cell_bench;
  localparam int LUT_IN = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  f_in_i = '0, g_in_i = '0;
  logic [3:0]  ctrl_i = 4'b1000;
  logic [15:0] cfg_f_tt_i = '0, cfg_g_tt_i = '0;
  logic [7:0]  cfg_h_tt_i = '0;
  logic [1:0]  cfg_h_src_i = '0;
  logic        cfg_x_h_i = 1'b0, cfg_y_h_i = 1'b0;
  logic [3:0]  cfg_dsel_i = 4'b1111;
  logic [1:0]  cfg_en_use_i = 2'b11, cfg_sr_use_i = 2'b00, cfg_srval_i = 2'b10;
  logic [1:0]  cfg_clk_inv_i = 2'b00, cfg_latch_i = 2'b00, cfg_byp_en_i = 2'b00;
  logic [3:0]  cfg_byp_src_i = '0;
  logic        x_o, y_o, xq_o, yq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  logic_cell #(.LUT_IN(LUT_IN)) u_logic_cell (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic at_pos;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic model_h(input logic [15:0] tf, input logic [15:0] tg,
                                   input logic [7:0] th, input logic [3:0] fi,
                                   input logic [3:0] gi, input logic [3:0] c,
                                   input logic [1:0] hs);
    logic a, b;
    a = hs[0] ? tf[fi] : c[2];
    b = hs[1] ? tg[gi] : c[1];
    return th[{b, c[0], a}];
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rnd;
    #1;
    // R7 power-up values under global set/reset
    chk("R7 powerup xq", xq_o, 1'b0);
    chk("R7 powerup yq", yq_o, 1'b1);

    // R1 R2 exhaustive sweep, registers held in reset
    for (int t = 0; t < 4; t++) begin
      rnd = $urandom(); cfg_f_tt_i = rnd[15:0];
      rnd = $urandom(); cfg_g_tt_i = rnd[15:0];
      rnd = $urandom(); cfg_h_tt_i = rnd[7:0];
      cfg_x_h_i = (t % 2 == 0);
      cfg_y_h_i = (t % 2 == 1);
      for (int hs = 0; hs < 4; hs++) begin
        for (int c = 0; c < 8; c++) begin
          for (int fi = 0; fi < 16; fi++) begin
            for (int gi = 0; gi < 16; gi++) begin
              cfg_h_src_i = hs[1:0];
              ctrl_i = {1'b0, c[2:0]};
              f_in_i = fi[3:0];
              g_in_i = gi[3:0];
              #1;
              if (cfg_x_h_i) begin
                chk("R2 x=H", x_o, model_h(cfg_f_tt_i, cfg_g_tt_i, cfg_h_tt_i,
                                           f_in_i, g_in_i, ctrl_i, cfg_h_src_i));
                chk("R1 y=G", y_o, cfg_g_tt_i[g_in_i]);
              end else begin
                chk("R1 x=F", x_o, cfg_f_tt_i[f_in_i]);
                chk("R2 y=H", y_o, model_h(cfg_f_tt_i, cfg_g_tt_i, cfg_h_tt_i,
                                           f_in_i, g_in_i, ctrl_i, cfg_h_src_i));
              end
            end
          end
        end
      end
    end

    // release global set/reset
    ctrl_i = 4'b1000;
    at_pos();
    rst_ni = 1'b1;

    // R3 direct input capture
    ctrl_i = 4'b1010;
    at_pos();
    chk("R3 din xq", xq_o, 1'b1);
    chk("R3 din yq", yq_o, 1'b1);
    ctrl_i = 4'b1000;
    at_pos();
    chk("R3 din0 xq", xq_o, 1'b0);
    chk("R3 din0 yq", yq_o, 1'b0);

    // R3 F, G, H sources
    cfg_h_src_i = 2'b11;
    cfg_dsel_i = {2'd1, 2'd2};
    f_in_i = 4'h5; g_in_i = 4'hA;
    at_pos();
    chk("R3 H xq", xq_o, model_h(cfg_f_tt_i, cfg_g_tt_i, cfg_h_tt_i,
                                 f_in_i, g_in_i, ctrl_i, cfg_h_src_i));
    chk("R3 G yq", yq_o, cfg_g_tt_i[g_in_i]);
    cfg_dsel_i = {2'd1, 2'd0};
    for (int k = 0; k < 4; k++) begin
      f_in_i = 4'(k * 5 + 3);
      g_in_i = 4'(k * 3 + 1);
      at_pos();
      chk("R3 F xq", xq_o, cfg_f_tt_i[f_in_i]);
      chk("R3 G yq", yq_o, cfg_g_tt_i[g_in_i]);
    end

    // R5 enable
    cfg_dsel_i = 4'b1111;
    ctrl_i = 4'b1010;
    at_pos();
    ctrl_i = 4'b0000;
    at_pos();
    chk("R5 hold xq", xq_o, 1'b1);
    chk("R5 hold yq", yq_o, 1'b1);
    cfg_en_use_i = 2'b00;
    at_pos();
    chk("R5 unused enable xq", xq_o, 1'b0);

    // R4 clock inversion on X only
    at_pos();
    cfg_clk_inv_i = 2'b01;
    ctrl_i = 4'b0010;
    #2;
    chk("R4 no rise capture xq", xq_o, 1'b0);
    @(negedge clk_i); #1;
    chk("R4 fall capture xq", xq_o, 1'b1);
    chk("R4 y not on fall", yq_o, 1'b0);
    at_pos();
    chk("R4 y on rise", yq_o, 1'b1);
    cfg_clk_inv_i = 2'b00;

    // R6 local set/reset
    cfg_en_use_i = 2'b11;
    ctrl_i = 4'b1000;
    at_pos();
    at_pos();
    cfg_srval_i = 2'b01;
    cfg_sr_use_i = 2'b01;
    ctrl_i = 4'b0100;
    #1;
    chk("R6 async set xq", xq_o, 1'b1);
    chk("R6 disabled yq", yq_o, 1'b0);
    ctrl_i = 4'b1100;
    at_pos();
    chk("R6 overrides clock xq", xq_o, 1'b1);
    chk("R6 disabled yq edge", yq_o, 1'b0);
    ctrl_i = 4'b1000;
    at_pos();
    chk("R6 release xq", xq_o, 1'b0);

    // R7 global set/reset mid-run
    cfg_srval_i = 2'b11;
    rst_ni = 1'b0;
    #1;
    chk("R7 global xq", xq_o, 1'b1);
    chk("R7 global yq", yq_o, 1'b1);
    rst_ni = 1'b1;
    cfg_sr_use_i = 2'b00;
    at_pos();
    chk("R7 after release xq", xq_o, 1'b0);

    // R8 latch mode on X
    cfg_latch_i = 2'b01;
    ctrl_i = 4'b1010;
    #1;
    chk("R8 transparent 1", xq_o, 1'b1);
    ctrl_i = 4'b1000;
    #1;
    chk("R8 transparent 0", xq_o, 1'b0);
    @(negedge clk_i); #1;
    ctrl_i = 4'b0010;
    #1;
    chk("R8 hold clock low", xq_o, 1'b0);
    at_pos();
    chk("R8 hold enable low", xq_o, 1'b0);
    ctrl_i = 4'b1010;
    #1;
    chk("R8 reopen", xq_o, 1'b1);
    cfg_latch_i = 2'b00;

    // R9 bypass: X from ctrl 0, Y from ctrl 3
    cfg_byp_src_i = 4'b1100;
    cfg_byp_en_i = 2'b11;
    ctrl_i = 4'b0001;
    #1;
    chk("R9 bypass xq", xq_o, 1'b1);
    chk("R9 bypass yq", yq_o, 1'b0);
    ctrl_i = 4'b1000;
    #1;
    chk("R9 bypass xq 0", xq_o, 1'b0);
    chk("R9 bypass yq 1", yq_o, 1'b1);

    at_pos();
    finish_run();
  end
endmodule